// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers interrupt requests from a parameterised set of lines and decides, once per completed instruction, whether the sequencer should divert to an interrupt routine. A rising edge on a request line sets a sticky pending bit for that line. A per-line enable mask selects which pending bits may win. A single global block flag suppresses all diversions while it is set. When a diversion is taken, the block reports a vector address formed from a base parameter plus the index of the winning line. The highest line index wins.

Taking a diversion sets the block flag by itself. Software may set the flag or clear it with commands that arrive together with the end of an instruction. A set takes effect at that same boundary. A clear waits until one more instruction has completed, so the instruction that follows the clearing one always runs to its end. Requests that arrive while the flag is set are held in the pending register. The mask can be written from a data word or swapped with one. The pending register is visible on its own port, and reading it changes nothing.

The instruction decoder and the memory side of the mask swap are outside this block. It sees only the register ports listed below.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A 0-to-1 transition on a bit of `irq_in`, compared with the value sampled on the previous clock, sets the matching bit of `pending_o` on the next clock. A line held high does not set its bit again once that bit has been cleared, and pending bits never clear except as described in R5.
- R2: When several enabled pending lines exist at a boundary, the winner is the one with the highest bit index, and `vector_o` equals `VEC_BASE` plus that index.
- R3: A pending line whose `mask_o` bit is 0 is never taken and keeps its pending bit set.
- R4: A diversion is taken only in a cycle with `instr_done` high, at least one bit set in `pending_o & mask_o`, and the block not in effect. `take_o` pulses high for one cycle on the clock after that boundary, and `vector_o` is updated on the same clock and then held.
- R5: Taking a diversion sets `block_o` and clears only the winner's pending bit, on the same clock on which `take_o` rises.
- R6: Requests that are pending or that arrive while the block is set stay in `pending_o` and are taken once the block has been lifted.
- R7: `blk_set` with `instr_done` suppresses any diversion at that boundary, and `block_o` reads 1 on the next clock.
- R8: `blk_clr` with `instr_done` (boundary k) does not lift the block at k. At the next boundary with `instr_done`, the block counts as clear, so a diversion may be taken there. If none is taken, `block_o` reads 0 after that boundary. `blk_set` overrides `blk_clr`.
- R9: `mask_wr` high loads `mask_din` into `mask_o` on the next clock.
- R10: `mask_xchg` high loads `mask_din` into the mask, and on the same clock places the previous mask value on `xchg_dout`.
- R11: After reset, `pending_o`, `mask_o`, `xchg_dout` and `vector_o` are 0, and `block_o` and `take_o` are 0.
- R12: A new rising edge on the line that is being taken at the same boundary leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Raw request lines, edge-captured |
| instr_done | input | 1 | Instruction boundary strobe |
| blk_set | input | 1 | Set block flag, qualified by instr_done |
| blk_clr | input | 1 | Delayed clear of block flag, qualified by instr_done |
| mask_wr | input | 1 | Load mask from mask_din |
| mask_xchg | input | 1 | Swap mask with mask_din |
| mask_din | input | NUM_LINES | Data word for mask load or swap |
| take_o | output | 1 | One-cycle pulse: diversion taken |
| vector_o | output | VEC_W | Vector address of the last diversion |
| pending_o | output | NUM_LINES | Pending request register |
| mask_o | output | NUM_LINES | Enable mask register |
| xchg_dout | output | NUM_LINES | Previous mask returned by a swap |
| block_o | output | 1 | Block flag state |

## Verification
The bench builds the controller with twelve request lines, so the winner search crosses two groups of six. The highest-index rule can therefore be exercised across a group border, where a wrong group ordering shows up. A vector base of 0x200 makes any error in the base-plus-index sum visible. Random request edges, mask writes and swaps, and block commands are mixed with directed sequences. These directed sequences cover the one-instruction delay on clear, set overriding clear, masked lines, and a re-raise coinciding with a take.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // request lines are organised in groups of this size
  localparam int unsigned LINE_GROUP = 6;
  localparam int unsigned MAX_LINES  = 24;

  typedef struct packed {
    logic set;
    logic clr;
  } blk_cmd_t;
endpackage

// File: rtl/prio_irq_capture.sv
module prio_irq_capture #(
  parameter int unsigned NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] clr_vec,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_in;
      // a fresh edge wins over the clear of a taken line
      pend_q <= (pend_q & ~clr_vec) | rise;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/prio_irq_enc.sv
module prio_irq_enc
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 6,
  parameter int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  localparam int unsigned GROUPS = NUM_LINES / LINE_GROUP;

  logic [IDX_W-1:0] chain_idx [GROUPS+1];
  logic             chain_any [GROUPS+1];

  assign chain_idx[0] = '0;
  assign chain_any[0] = 1'b0;

  // later (higher) groups override earlier ones
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [2:0] lidx;
    logic       lany;

    always_comb begin
      lidx = '0;
      lany = 1'b0;
      for (int j = 0; j < LINE_GROUP; j++) begin
        if (req[g*LINE_GROUP + j]) begin
          lidx = 3'(j);
          lany = 1'b1;
        end
      end
    end

    assign chain_any[g+1] = chain_any[g] | lany;
    assign chain_idx[g+1] = lany ? (IDX_W'(g*LINE_GROUP) + IDX_W'(lidx))
                                 : chain_idx[g];
  end

  assign any_o = chain_any[GROUPS];
  assign idx_o = chain_idx[GROUPS];
endmodule

// File: rtl/prio_irq_block.sv
module prio_irq_block
  import prio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     instr_done,
  input  blk_cmd_t cmd,
  input  logic     take,
  output logic     eff_blk_o,
  output logic     block_o
);
  logic blk_q;
  logic arm_q;

  // block as seen by the decision at this boundary
  assign eff_blk_o = cmd.set | (blk_q & ~arm_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (instr_done) begin
      if (cmd.set || take) begin
        blk_q <= 1'b1;
        arm_q <= 1'b0;
      end else if (arm_q) begin
        blk_q <= 1'b0;
        arm_q <= cmd.clr;
      end else if (cmd.clr) begin
        arm_q <= 1'b1;
      end
    end
  end

  assign block_o = blk_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 6,
  parameter int unsigned VEC_W     = 16,
  parameter int unsigned VEC_BASE  = 32'h0040
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 instr_done,
  input  logic                 blk_set,
  input  logic                 blk_clr,
  input  logic                 mask_wr,
  input  logic                 mask_xchg,
  input  logic [NUM_LINES-1:0] mask_din,
  output logic                 take_o,
  output logic [VEC_W-1:0]     vector_o,
  output logic [NUM_LINES-1:0] pending_o,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] xchg_dout,
  output logic                 block_o
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] xdout_q;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] elig;
  logic                 any_elig;
  logic [IDX_W-1:0]     win_idx;
  logic                 eff_blk;
  logic                 take;
  logic                 take_q;
  logic [VEC_W-1:0]     vec_q;
  blk_cmd_t             cmd;

  assign cmd.set = blk_set;
  assign cmd.clr = blk_clr;

  prio_irq_capture #(.NUM_LINES(NUM_LINES)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .clr_vec(clr_vec),
    .pend_o (pend)
  );

  assign elig = pend & mask_q;

  prio_irq_enc #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_enc (
    .req  (elig),
    .any_o(any_elig),
    .idx_o(win_idx)
  );

  assign take = instr_done & any_elig & ~eff_blk;

  prio_irq_block u_blk (
    .clk       (clk),
    .rst       (rst),
    .instr_done(instr_done),
    .cmd       (cmd),
    .take      (take),
    .eff_blk_o (eff_blk),
    .block_o   (block_o)
  );

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      xdout_q <= '0;
      take_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (mask_wr || mask_xchg) mask_q <= mask_din;
      if (mask_xchg)            xdout_q <= mask_q;
      take_q <= take;
      if (take) vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end
  end

  assign take_o    = take_q;
  assign vector_o  = vec_q;
  assign pending_o = pend;
  assign mask_o    = mask_q;
  assign xchg_dout = xdout_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NUM_LINES = 6,
  parameter int unsigned VEC_W     = 16,
  parameter int unsigned VEC_BASE  = 32'h0040
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 instr_done,
  input logic                 blk_set,
  input logic                 mask_wr,
  input logic                 mask_xchg,
  input logic [NUM_LINES-1:0] mask_din,
  input logic                 take_o,
  input logic [VEC_W-1:0]     vector_o,
  input logic [NUM_LINES-1:0] pending_o,
  input logic [NUM_LINES-1:0] mask_o,
  input logic [NUM_LINES-1:0] xchg_dout,
  input logic                 block_o
);
  logic [VEC_W-1:0] win;
  assign win = vector_o - VEC_W'(VEC_BASE);

  // R4: a take follows a boundary
  a_r4_take_at_boundary: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(instr_done));

  // R5: taking leaves the block set
  a_r5_take_sets_block: assert property (@(posedge clk) disable iff (rst)
    take_o |-> block_o);

  // R7: a set command at the boundary forbids a take there
  a_r7_set_suppresses: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !$past(blk_set));

  // R2 and R3: winner is enabled and no higher enabled line was pending
  a_r2_highest_wins: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (($past(mask_o & pending_o) >> win) == NUM_LINES'(1)));

  // R1: pending bits only drop when a take happens, one at a time
  a_r1_pending_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(pending_o) & ~pending_o) != '0) |-> take_o);

  a_r5_single_clear: assert property (@(posedge clk) disable iff (rst)
    $countones($past(pending_o) & ~pending_o) <= 1);

  // R9: mask load
  a_r9_mask_load: assert property (@(posedge clk) disable iff (rst)
    $past(mask_wr || mask_xchg) |-> (mask_o == $past(mask_din)));

  // R10: swap returns the old mask
  a_r10_swap_out: assert property (@(posedge clk) disable iff (rst)
    $past(mask_xchg) |-> (xchg_dout == $past(mask_o)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr_done(instr_done),
  .blk_set   (blk_set),
  .mask_wr   (mask_wr),
  .mask_xchg (mask_xchg),
  .mask_din  (mask_din),
  .take_o    (take_o),
  .vector_o  (vector_o),
  .pending_o (pending_o),
  .mask_o    (mask_o),
  .xchg_dout (xchg_dout),
  .block_o   (block_o)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int unsigned N    = 12;
  localparam int unsigned VW   = 16;
  localparam int unsigned BASE = 32'h0200;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  irq_in;
  logic          instr_done, blk_set, blk_clr, mask_wr, mask_xchg;
  logic [N-1:0]  mask_din;
  logic          take_o, block_o;
  logic [VW-1:0] vector_o;
  logic [N-1:0]  pending_o, mask_o, xchg_dout;

  int n_chk  = 0;
  int n_fail = 0;

  // reference state built from the requirements
  logic [N-1:0]  m_prev, m_pend, m_mask, m_xd;
  logic          m_blk, m_arm, m_take;
  logic [VW-1:0] m_vec;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(N), .VEC_W(VW), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .instr_done(instr_done),
    .blk_set(blk_set), .blk_clr(blk_clr), .mask_wr(mask_wr),
    .mask_xchg(mask_xchg), .mask_din(mask_din), .take_o(take_o),
    .vector_o(vector_o), .pending_o(pending_o), .mask_o(mask_o),
    .xchg_dout(xchg_dout), .block_o(block_o)
  );

  function automatic int top_bit(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare_model();
    chk("R1 pending",  32'(pending_o), 32'(m_pend));
    chk("R4 take",     32'(take_o),    32'(m_take));
    chk("R2 vector",   32'(vector_o),  32'(m_vec));
    chk("R9 mask",     32'(mask_o),    32'(m_mask));
    chk("R10 swapout", 32'(xchg_dout), 32'(m_xd));
    chk("R8 block",    32'(block_o),   32'(m_blk));
  endtask

  // drive one cycle at the falling edge, predict, compare at next falling edge
  task automatic step(input logic [N-1:0] irq, input logic done, input logic set,
                      input logic clr, input logic wr, input logic xchg,
                      input logic [N-1:0] din);
    logic [N-1:0] elig, rise, clrv;
    logic eff, tk;
    int w;
    irq_in = irq; instr_done = done; blk_set = set; blk_clr = clr;
    mask_wr = wr; mask_xchg = xchg; mask_din = din;
    rise = irq & ~m_prev;
    elig = m_pend & m_mask;
    eff  = set | (m_blk & ~m_arm);
    tk   = done && (elig != '0) && !eff;
    w    = top_bit(elig);
    clrv = '0;
    if (tk) clrv[w] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_prev = irq;
    m_pend = (m_pend & ~clrv) | rise;
    if (xchg) m_xd = m_mask;
    if (wr || xchg) m_mask = din;
    m_take = tk;
    if (tk) m_vec = VW'(BASE) + VW'(w);
    if (done) begin
      if (set || tk) begin m_blk = 1'b1; m_arm = 1'b0; end
      else if (m_arm) begin m_blk = 1'b0; m_arm = clr; end
      else if (clr) m_arm = 1'b1;
    end
    compare_model();
  endtask

  logic [N-1:0] cur_irq;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; irq_in = '0; instr_done = 0; blk_set = 0; blk_clr = 0;
    mask_wr = 0; mask_xchg = 0; mask_din = '0;
    m_prev = '0; m_pend = '0; m_mask = '0; m_xd = '0;
    m_blk = 0; m_arm = 0; m_take = 0; m_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 pending", 32'(pending_o), 0);
    chk("R11 mask",    32'(mask_o), 0);
    chk("R11 block",   32'(block_o), 0);
    chk("R11 take",    32'(take_o), 0);
    chk("R11 vector",  32'(vector_o), 0);

    cur_irq = 12'h014;
    step(cur_irq, 0, 0, 0, 0, 0, '0);
    chk("R1 edges captured", 32'(pending_o), 32'h014);
    step(cur_irq, 0, 0, 0, 1, 0, 12'hFFF);
    chk("R9 mask loaded", 32'(mask_o), 32'hFFF);
    step(cur_irq, 1, 0, 0, 0, 0, '0);
    chk("R2 winner line 4", 32'(vector_o), BASE + 4);
    chk("R5 only winner cleared", 32'(pending_o), 32'h004);
    chk("R5 block set", 32'(block_o), 1);
    cur_irq = 12'h094;
    step(cur_irq, 1, 0, 0, 0, 0, '0);
    chk("R6 no take while blocked", 32'(take_o), 0);
    chk("R6 held", 32'(pending_o), 32'h084);
    step(cur_irq, 1, 0, 1, 0, 0, '0);
    chk("R8 clear not yet", 32'(block_o), 1);
    chk("R8 no take at clear", 32'(take_o), 0);
    step(cur_irq, 1, 0, 0, 0, 0, '0);
    chk("R8 take after delay", 32'(take_o), 1);
    chk("R8 vector line 7", 32'(vector_o), BASE + 7);
    step(cur_irq, 1, 0, 1, 0, 0, '0);
    step(cur_irq, 1, 1, 0, 0, 0, '0);
    chk("R7 set suppresses", 32'(take_o), 0);
    chk("R7 block on", 32'(block_o), 1);
    step(cur_irq, 0, 0, 0, 0, 1, 12'h0F0);
    chk("R10 old mask out", 32'(xchg_dout), 32'hFFF);
    chk("R10 new mask", 32'(mask_o), 32'h0F0);
    step(cur_irq, 1, 0, 1, 0, 0, '0);
    step(cur_irq, 1, 0, 0, 0, 0, '0);
    chk("R3 masked not taken", 32'(take_o), 0);
    chk("R3 still pending", 32'(pending_o), 32'h004);
    chk("R8 block lifted", 32'(block_o), 0);
    step(cur_irq, 0, 0, 0, 1, 0, 12'hFFF);
    cur_irq = 12'h090;
    step(cur_irq, 0, 0, 0, 0, 0, '0);
    cur_irq = 12'h094;
    step(cur_irq, 1, 0, 0, 0, 0, '0);
    chk("R12 taken line 2", 32'(vector_o), BASE + 2);
    chk("R12 re-raised stays", 32'(pending_o), 32'h004);

    // randomised traffic checked against the reference state
    for (int c = 0; c < 4000; c++) begin
      logic d, s, cl, wr, xc;
      logic [N-1:0] din;
      if ($urandom % 3 == 0) cur_irq ^= N'(1) << ($urandom % N);
      d   = ($urandom % 3) == 0;
      s   = d && (($urandom % 10) == 0);
      cl  = d && (($urandom % 4) == 0);
      wr  = ($urandom % 25) == 0;
      xc  = ($urandom % 30) == 0;
      din = N'($urandom);
      step(cur_irq, d, s, cl, wr, xc, din);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule